// File: doc/BRIEF.md
# Register-File LIFO Stack with Wrap-Detected Full and Empty Flags

This block is a last-in, first-out store built from a small register file, a wrapping stack pointer and two one-bit status registers. A push advances the pointer and then writes the incoming word at the new pointer. A pop reads the word under the pointer into a registered output and then steps the pointer back. The pointer is as wide as the address of the store, so it wraps at both ends. Full and empty are therefore not counted. They are recorded when a push or a pop leaves the pointer at zero. The first word pushed lands at address 1, and the word that fills the store lands at address 0.

The surrounding logic drives one request per cycle. When push and pop are raised together, the push is taken and the pop is dropped. A push while full or a pop while empty changes nothing, and the block answers it with a one-cycle error strobe. Popped data, the valid strobe, the flags and the error strobe all come from registers, so every result appears one clock after the request that caused it.

Top module: `lifo_regstack`

## Requirements
- R1: After synchronous reset, empty_o is 1, and full_o, err_o and pop_valid_o are 0.
- R2: An accepted push stores push_data_i, and empty_o is 0 from the cycle after the push.
- R3: An accepted pop returns the most recently pushed word that has not yet been popped, on pop_data_o with pop_valid_o high, in the cycle after the request.
- R4: full_o rises only in the cycle after the push that stores the DEPTH-th word, when the pointer has wrapped to 0. After DEPTH-1 pushes from empty it is still 0.
- R5: A push while full_o is 1 stores nothing and raises err_o for one cycle. full_o stays 1, and the next pop still returns the last word accepted.
- R6: A pop clears full_o. When a pop brings the pointer back to 0, empty_o becomes 1 in the following cycle.
- R7: A pop while empty_o is 1 raises err_o for one cycle, gives no pop_valid_o pulse and leaves empty_o at 1.
- R8: When push_i and pop_i are both high and the stack is not full, only the push is done: there is no pop_valid_o pulse, and the word is stored.
- R9: err_o and pop_valid_o are single-cycle pulses that never occur together. With no request, the flags do not change and pop_data_o keeps the last popped word.
- R10: When push_i and pop_i are both high while full, err_o pulses and no pop takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request; has priority over pop_i |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DW | Word to push |
| pop_data_o | output | DW | Registered popped word, held between pops |
| pop_valid_o | output | 1 | One-cycle pulse: pop_data_o was just updated |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
Every output of this block is due exactly one rising edge after the request that causes it. This covers popped data, the valid strobe, both flags and the error strobe. The driver applies each request on a falling edge and holds it through one rising edge. It then reads the flags, err_o and pop_valid_o shortly after that edge, before the next request is applied. Each expected popped word goes into a queue when its pop is issued. A monitor takes the word from the queue at the next falling edge, where pop_valid_o for that request must be high, so each result is compared in the single cycle in which it becomes valid.

// File: rtl/lifo_regstack_pkg.sv
package lifo_regstack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lifo_regstack_ctrl.sv
module lifo_regstack_ctrl
  import lifo_regstack_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op
);
  // push wins over pop; a request against a flag is rejected
  always_comb begin
    if (push_i) begin
      op = full ? OP_REJECT : OP_PUSH;
    end else if (pop_i) begin
      op = empty ? OP_REJECT : OP_POP;
    end else begin
      op = OP_IDLE;
    end
  end
endmodule

// File: rtl/lifo_regstack_ptr.sv
module lifo_regstack_ptr
  import lifo_regstack_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_inc,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] sp_dec;

  assign sp_inc = sp + ONE;
  assign sp_dec = sp - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
    end else begin
      err <= (op == OP_REJECT);
      case (op)
        OP_PUSH: begin
          sp    <= sp_inc;
          full  <= (sp_inc == '0);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_dec;
          empty <= (sp_dec == '0);
          full  <= 1'b0;
        end
        default: begin
        end
      endcase
    end
  end

  // R2: an accepted push advances the pointer by one
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> (sp == $past(sp) + ONE));

  // R6: an accepted pop steps the pointer back by one
  p_pop_step_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP) |=> (sp == $past(sp) - ONE));

  // R5: a rejected request freezes pointer and flags and strobes err
  p_reject_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_REJECT) |=> ($stable(sp) && $stable(full) && $stable(empty) && err));

  // R4: the two flags are never raised together
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R4: full only ever stands with the pointer wrapped to zero
  p_full_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    full |-> (sp == '0));

  // R6: empty only ever stands with the pointer at zero
  p_empty_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    empty |-> (sp == '0));
endmodule

// File: rtl/lifo_regstack_mem.sv
module lifo_regstack_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] ram [DEPTH];

  // simple dual-port array, written for block RAM inference
  always_ff @(posedge clk) begin
    if (we) begin
      ram[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= ram[raddr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
    end
  end

  // R9: a write and a read never address the same word in one cycle
  p_port_split_r9: assert property (@(posedge clk) disable iff (rst)
    !(we && re));
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import lifo_regstack_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam int AW = $clog2(DEPTH);

  stk_op_e       op;
  logic [AW-1:0] sp;
  logic [AW-1:0] sp_inc;

  lifo_regstack_ctrl u_ctrl (
    .push_i (push_i),
    .pop_i  (pop_i),
    .full   (full_o),
    .empty  (empty_o),
    .op     (op)
  );

  lifo_regstack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .sp     (sp),
    .sp_inc (sp_inc),
    .full   (full_o),
    .empty  (empty_o),
    .err    (err_o)
  );

  lifo_regstack_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .we     (op == OP_PUSH),
    .waddr  (sp_inc),
    .wdata  (push_data_i),
    .re     (op == OP_POP),
    .raddr  (sp),
    .rdata  (pop_data_o),
    .rvalid (pop_valid_o)
  );

  // R3: a pop against a non-empty stack yields valid data next cycle
  p_pop_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !empty_o) |=> pop_valid_o);

  // R8: a simultaneous request never produces popped data
  p_push_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> !pop_valid_o);

  // R10: both requests while full are rejected
  p_both_full_r10: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && full_o) |=> (err_o && !pop_valid_o));

  // R7: a pop while empty is rejected and keeps empty
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_o) |=> (err_o && empty_o));

  // R9: error and valid strobes never coincide
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !(err_o && pop_valid_o));
endmodule

// File: tb/tb_lifo_regstack.sv
module tb_lifo_regstack;
  localparam int DW    = 16;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o;
  logic          pop_valid_o;
  logic          full_o;
  logic          empty_o;
  logic          err_o;

  int checks = 0;
  int fails  = 0;
  int model[$];
  int exp_q[$];
  string tag_q[$];
  int last_pop = 0;

  always #5 clk = ~clk;

  lifo_regstack #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .err_o       (err_o)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compare popped words against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && pop_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected pop_valid", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(pop_data_o == DW'(e), t, "pop_data", int'(pop_data_o), e);
      end
    end
  end

  // driver: one request per cycle, expected results from the model
  task automatic cyc(input logic ps, input logic pp, input int d, input string tag);
    logic e_err;
    logic e_pv;
    e_err = 1'b0;
    e_pv  = 1'b0;
    if (ps) begin
      if (model.size() == DEPTH) e_err = 1'b1;
      else model.push_back(d);
    end else if (pp) begin
      if (model.size() == 0) e_err = 1'b1;
      else begin
        last_pop = model.pop_back();
        exp_q.push_back(last_pop);
        tag_q.push_back(tag);
        e_pv = 1'b1;
      end
    end
    @(negedge clk);
    push_i = ps;
    pop_i = pp;
    push_data_i = DW'(d);
    @(posedge clk);
    #1;
    check(err_o == e_err, tag, "err_o", int'(err_o), int'(e_err));
    check(pop_valid_o == e_pv, tag, "pop_valid_o", int'(pop_valid_o), int'(e_pv));
    check(full_o == (model.size() == DEPTH), tag, "full_o", int'(full_o),
          int'(model.size() == DEPTH));
    check(empty_o == (model.size() == 0), tag, "empty_o", int'(empty_o),
          int'(model.size() == 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(empty_o == 1'b1, "R1", "empty_o", int'(empty_o), 1);
    check(full_o == 1'b0, "R1", "full_o", int'(full_o), 0);
    check(err_o == 1'b0, "R1", "err_o", int'(err_o), 0);
    check(pop_valid_o == 1'b0, "R1", "pop_valid_o", int'(pop_valid_o), 0);
    @(negedge clk);
    rst = 1'b0;

    cyc(1'b0, 1'b1, 0, "R7");
    cyc(1'b0, 1'b0, 0, "R7");
    cyc(1'b1, 1'b0, 16'h1111, "R2");
    cyc(1'b1, 1'b0, 16'h2222, "R2");
    cyc(1'b1, 1'b0, 16'h3333, "R2");
    cyc(1'b0, 1'b1, 0, "R3");
    cyc(1'b1, 1'b1, 16'h4444, "R8");
    cyc(1'b0, 1'b1, 0, "R8");
    cyc(1'b0, 1'b0, 0, "R9");
    check(pop_data_o == DW'(last_pop), "R9", "pop_data hold", int'(pop_data_o), last_pop);
    cyc(1'b0, 1'b1, 0, "R3");
    cyc(1'b0, 1'b1, 0, "R6");
    cyc(1'b0, 1'b1, 0, "R7");

    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 1'b0, i * 37 + 5, "R4");
    cyc(1'b1, 1'b0, 16'hBEEF, "R4");
    cyc(1'b1, 1'b0, 16'hDEAD, "R5");
    cyc(1'b1, 1'b1, 16'hCAFE, "R10");
    cyc(1'b0, 1'b1, 0, "R5");
    cyc(1'b0, 1'b0, 0, "R9");
    check(pop_data_o == 16'hBEEF, "R9", "pop_data hold", int'(pop_data_o), 16'hBEEF);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b0, 1'b1, 0, "R6");
    cyc(1'b0, 1'b1, 0, "R7");

    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b0, 16'hA000 + i, "R2");
      if (i % 3 == 2) cyc(1'b0, 1'b1, 0, "R3");
    end
    while (model.size() > 0) cyc(1'b0, 1'b1, 0, "R3");
    cyc(1'b0, 1'b0, 0, "R6");

    @(negedge clk);
    check(exp_q.size() == 0, "R3", "pending pops", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule